// File: doc/BRIEF.md
# Host Firmware-Cycle Address Remap Window

This block sits between a host's firmware-space request path and a local bus. Each host request carries a 32-bit address, a direction and a one-cycle strobe. The block compares the upper half of the address with a programmed host-side window. If the request falls inside that window and host access is switched on, the block forwards a local bus address one cycle later. The upper half of that address is a bitwise merge of a programmed local base and the request bits that the window lets through. The lower half passes through unchanged, so windows are sized and placed in 64 KiB steps.

Software sets up the window through a small register port. That port writes on a strobe and reads back without delay. The translation register holds two 16-bit bases. The mask register holds two 16-bit masks: one marks the bits taken from the local base, the other marks the bits kept from the request. A window of size S, where S is a power of two and at least 64 KiB, uses a replace mask equal to the upper half of ~(S-1) and a keep mask equal to (S>>16)-1. Its host base must be a multiple of S.

A request that misses the window, or that arrives while access is off, produces a miss strobe and sets a sticky status flag. Software clears that flag by writing 1 to it.

Top module: `fw_remap_window`

## Requirements
- R1: After reset, all four registers read as zero, and `fwd_valid`, `miss_pulse` and `mode_sel` are low.
- R2: Register select uses `cfg_addr[3:2]`: 0x0 is enable, 0x4 is mode/status, 0x8 is translation ({local base[31:16], host base[15:0]}), 0xC is mask ({replace[31:16], keep[15:0]}). The enable, translation and mask registers read back all 32 written bits.
- R3: A request is forwarded only while enable bits 8 and 10 are both 1. Otherwise it counts as a miss.
- R4: A request hits when `(addr[31:16] & ~keep) == (host_base & ~keep)`.
- R5: On a hit, `fwd_addr[31:16] = (local_base & replace) | (addr[31:16] & keep)`.
- R6: On a hit, `fwd_addr[15:0]` equals the request's `addr[15:0]`, and `fwd_we` equals the request's `host_we`.
- R7: For every `host_req`, exactly one of `fwd_valid` or `miss_pulse` is high for one cycle, in the clock cycle that follows the request. The two are never high together.
- R8: A miss sets status bit 0 of the mode/status register at the same edge that raises `miss_pulse`. Writing 1 to bit 0 clears it. Writing 0 leaves it set.
- R9: Bit 17 of the mode/status register is an ordinary read/write bit and drives `mode_sel`. A write to that register sets bit 17 from the written data and does not touch any status flag except through a 1 in bit 0. Bits other than 0 and 17 read as zero.
- R10: If a miss and a write-1 clear of bit 0 occur at the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read data for the register at `cfg_addr` (combinational) |
| host_req | input | 1 | Host request strobe |
| host_we | input | 1 | Request direction (1 = write) |
| host_addr | input | 32 | Host firmware-space address |
| fwd_valid | output | 1 | One-cycle forward strobe |
| fwd_addr | output | 32 | Translated local address |
| fwd_we | output | 1 | Forwarded direction |
| miss_pulse | output | 1 | One-cycle miss/disabled strobe |
| mode_sel | output | 1 | Mode-select level |

## Verification
The random phase draws power-of-two window sizes, random bases and addresses both inside and outside the window. Any wrong enable, base or mask state therefore shows up one cycle after the next request: either the strobe is wrong (forward instead of miss, or the reverse) or the upper address half is wrong. A stuck or lost status flag shows up on the next read of the mode/status register. The same-edge race between setting and clearing that flag is driven on purpose.

// File: rtl/fw_remap_pkg.sv
package fw_remap_pkg;
   // register select taken from byte offset bits [3:2]
   typedef enum logic [1:0] {
      SEL_ENABLE = 2'd0,
      SEL_MODE   = 2'd1,
      SEL_XLAT   = 2'd2,
      SEL_MASK   = 2'd3
   } cfg_sel_e;
endpackage

// File: rtl/remap_cfg_regs.sv
module remap_cfg_regs
   import fw_remap_pkg::*;
#(
   parameter int SEG_W     = 16,
   parameter int EN_BIT_A  = 8,
   parameter int EN_BIT_B  = 10,
   parameter int MODE_BIT  = 17,
   parameter int MISS_BIT  = 0
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  cfg_sel_e             cfg_sel,
   input  logic [2*SEG_W-1:0]   cfg_wdata,
   output logic [2*SEG_W-1:0]   cfg_rdata,
   input  logic                 miss_evt,
   output logic                 access_en,
   output logic                 mode_sel,
   output logic                 miss_flag,
   output logic [SEG_W-1:0]     local_base,
   output logic [SEG_W-1:0]     host_base,
   output logic [SEG_W-1:0]     repl_mask,
   output logic [SEG_W-1:0]     keep_mask
);
   localparam int DW = 2*SEG_W;

   logic [DW-1:0] enable_q, xlat_q, mask_q;
   logic          mode_q, miss_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         enable_q <= '0;
         xlat_q   <= '0;
         mask_q   <= '0;
         mode_q   <= 1'b0;
         miss_q   <= 1'b0;
      end else begin
         if (cfg_we) begin
            unique case (cfg_sel)
               SEL_ENABLE: enable_q <= cfg_wdata;
               SEL_MODE:   mode_q   <= cfg_wdata[MODE_BIT];
               SEL_XLAT:   xlat_q   <= cfg_wdata;
               SEL_MASK:   mask_q   <= cfg_wdata;
            endcase
         end
         // hardware set has priority over the software clear
         if (miss_evt)
            miss_q <= 1'b1;
         else if (cfg_we && cfg_sel == SEL_MODE && cfg_wdata[MISS_BIT])
            miss_q <= 1'b0;
      end
   end

   always_comb begin
      cfg_rdata = '0;
      unique case (cfg_sel)
         SEL_ENABLE: cfg_rdata = enable_q;
         SEL_MODE: begin
            cfg_rdata[MODE_BIT] = mode_q;
            cfg_rdata[MISS_BIT] = miss_q;
         end
         SEL_XLAT:   cfg_rdata = xlat_q;
         SEL_MASK:   cfg_rdata = mask_q;
      endcase
   end

   assign access_en  = enable_q[EN_BIT_A] & enable_q[EN_BIT_B];
   assign mode_sel   = mode_q;
   assign miss_flag  = miss_q;
   assign local_base = xlat_q[DW-1:SEG_W];
   assign host_base  = xlat_q[SEG_W-1:0];
   assign repl_mask  = mask_q[DW-1:SEG_W];
   assign keep_mask  = mask_q[SEG_W-1:0];
endmodule

// File: rtl/remap_xlate.sv
module remap_xlate #(
   parameter int SEG_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req,
   input  logic                 req_we,
   input  logic [2*SEG_W-1:0]   req_addr,
   input  logic                 access_en,
   input  logic [SEG_W-1:0]     local_base,
   input  logic [SEG_W-1:0]     host_base,
   input  logic [SEG_W-1:0]     repl_mask,
   input  logic [SEG_W-1:0]     keep_mask,
   output logic                 miss_evt,
   output logic                 fwd_valid,
   output logic [2*SEG_W-1:0]   fwd_addr,
   output logic                 fwd_we,
   output logic                 miss_pulse
);
   localparam int DW = 2*SEG_W;

   logic [SEG_W-1:0] req_hi, merged_hi, diff_bits;
   logic             hit, take;

   assign req_hi = req_addr[DW-1:SEG_W];

   // per-bit merge and compare
   for (genvar b = 0; b < SEG_W; b++) begin : g_bit
      assign merged_hi[b] = (local_base[b] & repl_mask[b]) | (req_hi[b] & keep_mask[b]);
      assign diff_bits[b] = ~keep_mask[b] & (req_hi[b] ^ host_base[b]);
   end

   assign hit      = ~|diff_bits;
   assign take     = req & hit & access_en;
   assign miss_evt = req & ~(hit & access_en);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fwd_valid  <= 1'b0;
         miss_pulse <= 1'b0;
         fwd_addr   <= '0;
         fwd_we     <= 1'b0;
      end else begin
         fwd_valid  <= take;
         miss_pulse <= miss_evt;
         if (take) begin
            fwd_addr <= {merged_hi, req_addr[SEG_W-1:0]};
            fwd_we   <= req_we;
         end
      end
   end
endmodule

// File: rtl/fw_remap_window.sv
module fw_remap_window
   import fw_remap_pkg::*;
#(
   parameter int SEG_W    = 16,
   parameter int CFG_AW   = 4,
   parameter int EN_BIT_A = 8,
   parameter int EN_BIT_B = 10,
   parameter int MODE_BIT = 17,
   parameter int MISS_BIT = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [CFG_AW-1:0]   cfg_addr,
   input  logic [2*SEG_W-1:0]  cfg_wdata,
   output logic [2*SEG_W-1:0]  cfg_rdata,
   input  logic                host_req,
   input  logic                host_we,
   input  logic [2*SEG_W-1:0]  host_addr,
   output logic                fwd_valid,
   output logic [2*SEG_W-1:0]  fwd_addr,
   output logic                fwd_we,
   output logic                miss_pulse,
   output logic                mode_sel
);
   localparam int DW = 2*SEG_W;

   if (CFG_AW < 4) begin : g_bad_aw
      $error("CFG_AW must cover four word registers");
   end
   if (EN_BIT_A == EN_BIT_B || EN_BIT_A >= DW || EN_BIT_B >= DW) begin : g_bad_en
      $error("enable bits must be distinct and inside the word");
   end
   if (MODE_BIT >= DW || MISS_BIT >= DW || MODE_BIT == MISS_BIT) begin : g_bad_mode
      $error("mode and status bits must be distinct and inside the word");
   end

   cfg_sel_e         cfg_sel;
   logic             access_en, miss_flag, miss_evt;
   logic [SEG_W-1:0] local_base, host_base, repl_mask, keep_mask;

   assign cfg_sel = cfg_sel_e'(cfg_addr[3:2]);

   remap_cfg_regs #(
      .SEG_W(SEG_W), .EN_BIT_A(EN_BIT_A), .EN_BIT_B(EN_BIT_B),
      .MODE_BIT(MODE_BIT), .MISS_BIT(MISS_BIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .miss_evt(miss_evt), .access_en(access_en), .mode_sel(mode_sel), .miss_flag(miss_flag),
      .local_base(local_base), .host_base(host_base),
      .repl_mask(repl_mask), .keep_mask(keep_mask)
   );

   remap_xlate #(.SEG_W(SEG_W)) u_xlate (
      .clk(clk), .rst_n(rst_n),
      .req(host_req), .req_we(host_we), .req_addr(host_addr),
      .access_en(access_en),
      .local_base(local_base), .host_base(host_base),
      .repl_mask(repl_mask), .keep_mask(keep_mask),
      .miss_evt(miss_evt),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_we(fwd_we),
      .miss_pulse(miss_pulse)
   );
endmodule

// File: rtl/remap_window_chk.sv
module remap_window_chk #(
   parameter int SEG_W = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_req,
   input logic               host_we,
   input logic [2*SEG_W-1:0] host_addr,
   input logic               access_en,
   input logic               miss_flag,
   input logic               fwd_valid,
   input logic [2*SEG_W-1:0] fwd_addr,
   input logic               fwd_we,
   input logic               miss_pulse
);
   assert_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_valid && miss_pulse));

   assert_caused_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_valid || miss_pulse) |-> $past(host_req));

   assert_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
      host_req |=> (fwd_valid || miss_pulse));

   assert_low_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> (fwd_addr[SEG_W-1:0] == $past(host_addr[SEG_W-1:0])
                     && fwd_we == $past(host_we)));

   assert_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |-> $past(access_en));

   assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      miss_pulse |-> miss_flag);
endmodule

bind fw_remap_window remap_window_chk #(.SEG_W(SEG_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
   .access_en(access_en), .miss_flag(miss_flag),
   .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_we(fwd_we),
   .miss_pulse(miss_pulse)
);

// File: tb/fw_remap_window_tb.sv
module fw_remap_window_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        host_req = 1'b0;
   logic        host_we = 1'b0;
   logic [31:0] host_addr = '0;
   logic        fwd_valid, fwd_we, miss_pulse, mode_sel;
   logic [31:0] fwd_addr;

   int total = 0;
   int bad = 0;
   bit done = 0;

   // bench model of the programmed state
   logic [31:0] m_en, m_xlat, m_mask;

   always #(CLK_PERIOD/2) clk = ~clk;

   fw_remap_window u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .fwd_valid(fwd_valid), .fwd_addr(fwd_addr), .fwd_we(fwd_we),
      .miss_pulse(miss_pulse), .mode_sel(mode_sel)
   );

   function automatic bit exp_fwd(input logic [31:0] a);
      logic [15:0] keep;
      keep = m_mask[15:0];
      return m_en[8] && m_en[10] &&
             ((a[31:16] & ~keep) == (m_xlat[15:0] & ~keep));
   endfunction

   function automatic logic [31:0] exp_addr(input logic [31:0] a);
      return {(m_xlat[31:16] & m_mask[31:16]) | (a[31:16] & m_mask[15:0]), a[15:0]};
   endfunction

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [3:0] off, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = off; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      if (off == 4'h0) m_en = d;
      if (off == 4'h8) m_xlat = d;
      if (off == 4'hC) m_mask = d;
   endtask

   task automatic reg_rd(input logic [3:0] off, output logic [31:0] d);
      cfg_addr = off;
      #1;
      d = cfg_rdata;
   endtask

   // issue one request and check the result one edge later
   task automatic do_req(input logic [31:0] a, input logic we, input string tag);
      bit ef;
      logic [31:0] ea;
      ef = exp_fwd(a);
      ea = exp_addr(a);
      @(negedge clk);
      host_req = 1'b1; host_addr = a; host_we = we;
      @(negedge clk);
      host_req = 1'b0;
      check(fwd_valid == ef && miss_pulse == !ef, {tag, " R3 R4 R7 strobes"},
            {30'd0, fwd_valid, miss_pulse}, {30'd0, ef, !ef});
      if (ef) begin
         check(fwd_addr == ea, {tag, " R5 R6 address"}, fwd_addr, ea);
         check(fwd_we == we, {tag, " R6 direction"}, {31'd0, fwd_we}, {31'd0, we});
      end
   endtask

   task automatic program_window(input int k, input logic [15:0] lbase, input logic [15:0] hbase);
      logic [31:0] s;
      s = 32'h1 << (16 + k);
      reg_wr(4'h8, {lbase, hbase & ~16'((s >> 16) - 1)});
      reg_wr(4'hC, {16'(~(s - 1) >> 16), 16'((s >> 16) - 1)});
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'd4242));
      m_en = '0; m_xlat = '0; m_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < 4; i++) begin
         reg_rd(4'(i * 4), rd);
         check(rd == 0, "R1 reset register", rd, 0);
      end
      check(!fwd_valid && !miss_pulse && !mode_sel, "R1 reset outputs",
            {29'd0, fwd_valid, miss_pulse, mode_sel}, 0);

      // R2 readback of full words
      reg_wr(4'h0, 32'hA5A5_0000); reg_rd(4'h0, rd); check(rd == 32'hA5A5_0000, "R2 enable rb", rd, 32'hA5A5_0000);
      reg_wr(4'h8, 32'h1234_5678); reg_rd(4'h8, rd); check(rd == 32'h1234_5678, "R2 xlat rb", rd, 32'h1234_5678);
      reg_wr(4'hC, 32'hFFF0_000F); reg_rd(4'hC, rd); check(rd == 32'hFFF0_000F, "R2 mask rb", rd, 32'hFFF0_000F);

      // R3 one enable bit only -> miss
      program_window(0, 16'h8000, 16'h0040);
      reg_wr(4'h0, 32'h0000_0100);
      do_req(32'h0040_1234, 1'b0, "R3 bit8 only");
      reg_wr(4'h0, 32'h0000_0400);
      do_req(32'h0040_1234, 1'b0, "R3 bit10 only");
      reg_wr(4'h0, 32'h0000_0500);
      do_req(32'h0040_1234, 1'b1, "R3 both bits");
      do_req(32'h0041_0000, 1'b0, "R4 64KiB miss");

      // R8 status W1C behaviour, flag set by earlier misses
      reg_rd(4'h4, rd); check(rd[0] == 1'b1, "R8 flag set", rd, 32'h1);
      reg_wr(4'h4, 32'h0000_0000); reg_rd(4'h4, rd); check(rd[0] == 1'b1, "R8 write0 keeps", rd, 32'h1);
      reg_wr(4'h4, 32'h0000_0001); reg_rd(4'h4, rd); check(rd == 32'h0, "R8 write1 clears", rd, 32'h0);

      // R9 mode bit
      reg_wr(4'h4, 32'hFFFF_FFFE); reg_rd(4'h4, rd);
      check(rd == 32'h0002_0000 && mode_sel, "R9 mode set, others zero", rd, 32'h0002_0000);
      do_req(32'hFFFF_0000, 1'b0, "R9 miss");
      reg_wr(4'h4, 32'h0002_0001); reg_rd(4'h4, rd);
      check(rd == 32'h0002_0000 && mode_sel, "R9 mode kept by clear", rd, 32'h0002_0000);
      reg_wr(4'h4, 32'h0); reg_rd(4'h4, rd);
      check(rd == 32'h0 && !mode_sel, "R9 mode cleared", rd, 32'h0);

      // R10 set wins over simultaneous clear
      do_req(32'hFFFF_0000, 1'b0, "R10 prime");
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 4'h4; cfg_wdata = 32'h1;
      host_req = 1'b1; host_addr = 32'hFFFF_0000;
      @(negedge clk);
      cfg_we = 1'b0; host_req = 1'b0;
      reg_rd(4'h4, rd); check(rd[0] == 1'b1, "R10 set wins", rd, 32'h1);
      reg_wr(4'h4, 32'h1);

      // directed: largest window, keep all but top bit
      program_window(15, 16'hC000, 16'h0000);
      do_req(32'h7ABC_DEF0, 1'b1, "R5 big window");
      do_req(32'h8000_0001, 1'b0, "R4 big window miss");

      // random windows
      for (int n = 0; n < 300; n++) begin
         int k;
         logic [31:0] a, s;
         k = int'($urandom_range(0, 15));
         s = 32'h1 << (16 + k);
         program_window(k, 16'($urandom), 16'($urandom));
         if ($urandom_range(0, 7) == 0) reg_wr(4'h0, 32'($urandom));
         else reg_wr(4'h0, 32'h0000_0500 | 32'($urandom));
         if ($urandom_range(0, 2) != 0)
            a = {m_xlat[15:0], 16'h0} | ($urandom & (s - 1));
         else
            a = $urandom;
         do_req(a, 1'($urandom), "R5 random");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule